// File: doc/BRIEF.md
# Event Interval Packer and Serial Sender

After a capture run has filled an event memory with timestamped samples, this block walks through the stored entries in address order and turns each absolute timestamp into the time elapsed since the entry before it. The timestamps come from a free-running 21-bit microsecond counter that may have wrapped between two events, so the difference is taken modulo 2^21. Each result is packed, together with the three channel-state bits stored with the event, into a 24-bit record. The record is then sent as three bytes over an asynchronous serial transmitter whose bit timing is derived from the system clock.

A controller pulses `start` with the number of stored events on `evt_count`. The block raises `busy`, reads the memory through a synchronous read port with one cycle of latency, and sends every record. It drops `busy` once the stop bit of the final byte is on the line. A run with zero events sends nothing.

Top module: `evt_serializer`

## Requirements
- R1: Each record is 24 bits and goes out as three bytes. The first byte holds channel 0 state in bit 7, channel 1 in bit 6, channel 2 in bit 5, and interval bits 20..16 in bits 4..0. The second byte holds interval bits 15..8. The third byte holds interval bits 7..0. The memory word gives channel 0 in bit 23, channel 1 in bit 22, channel 2 in bit 21 and the timestamp in bits 20..0.
- R2: Records go out in address order 0 to `evt_count`-1, with the first byte of each record sent first. Exactly 3*`evt_count` bytes are sent per run.
- R3: For every event after the first, the interval is (timestamp minus previous timestamp) modulo 2^21. This covers a counter wrap and equal timestamps.
- R4: The interval of the first event of a run is zero.
- R5: Each byte uses 8N1 framing: one low start bit, eight data bits LSB first, one high stop bit. Each bit lasts round(CLK_HZ/BAUD_HZ) clock cycles, and BAUD_HZ defaults to 19200.
- R6: `busy` is high from the cycle after an accepted `start` until the stop bit of the last byte has completed. Whenever `busy` is low, `tx` is high.
- R7: A `start` with `evt_count` equal to zero sends no byte and leaves `busy` low.
- R8: A `start` pulse while `busy` is high is ignored; the running transfer continues with its original count.
- R9: The address presented on `rd_addr` is 0 when a run begins and, during a run, only holds or steps up by one. Read data is taken one cycle after its address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to send the stored events |
| evt_count | input | ADDR_W+1 | Number of stored events, sampled with an accepted start |
| rd_addr | output | ADDR_W | Event memory read address |
| rd_data | input | 24 | Event word, valid one cycle after its address |
| busy | output | 1 | High while a transfer is in progress |
| tx | output | 1 | Serial output, idle high |

## Verification
The assertions assume the event memory answers every address with a word one cycle later. They also assume `start` is a single-cycle pulse. They do not assume that `evt_count` stays fixed outside an accepted start: the bench deliberately changes it and pulses `start` during a run to exercise R8. Stimulus keeps counts within the bench memory depth and writes memory words only while the block is idle. It mixes seeded random timestamps and states with directed wrap, equal-timestamp and maximum-interval cases.

// File: rtl/evt_pkg.sv
// Shared widths and the record packing rule for the event serializer.
// Assumes a 21-bit wrapping microsecond timestamp and three channel bits.
package evt_pkg;
    localparam int TS_W  = 21;
    localparam int ST_W  = 3;
    localparam int REC_W = TS_W + ST_W;
    localparam int BYTES = REC_W / 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_CALC,
        S_LOAD,
        S_WAIT
    } ser_state_t;

    // Select byte k of a record, k = 0 being the most significant.
    function automatic logic [7:0] rec_byte(input logic [REC_W-1:0] rec,
                                            input logic [1:0] k);
        logic [7:0] b;
        b = 8'h00;
        for (int i = 0; i < BYTES; i++) begin
            if (k == i[1:0]) b = rec[REC_W-1-8*i -: 8];
        end
        return b;
    endfunction
endpackage

// File: rtl/evt_baud_gen.sv
// Bit-period tick generator. Counts system clocks while enabled and
// pulses tick every DIV cycles; held at zero while disabled so the
// first bit of a frame gets a full period. Assumes DIV >= 2.
module evt_baud_gen #(
    parameter int DIV = 2604
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CNT_W = $clog2(DIV + 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = en && (cnt_q == CNT_W'(DIV - 1));

    // Period counter, restarted whenever the transmitter is idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/evt_uart_tx.sv
// 8N1 serial transmitter. A load pulse while idle latches one byte and
// sends start, eight data bits LSB first, then stop. Assumes load is
// only asserted while active is low.
module evt_uart_tx #(
    parameter int DIV = 2604
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] data,
    output logic       active,
    output logic       tx
);
    localparam int FRAME = 10;

    logic [FRAME-1:0] sh_q;
    logic [3:0]       nbit_q;
    logic             active_q;
    logic             tick;

    evt_baud_gen #(.DIV(DIV)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (active_q),
        .tick (tick)
    );

    assign active = active_q;
    assign tx     = active_q ? sh_q[0] : 1'b1;

    // Frame shifter: load the frame, then shift one bit per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= '1;
            nbit_q   <= '0;
            active_q <= 1'b0;
        end else if (load && !active_q) begin
            sh_q     <= {1'b1, data, 1'b0};
            nbit_q   <= '0;
            active_q <= 1'b1;
        end else if (tick) begin
            sh_q   <= {1'b1, sh_q[FRAME-1:1]};
            nbit_q <= nbit_q + 1'b1;
            if (nbit_q == 4'(FRAME - 1)) active_q <= 1'b0;
        end
    end
endmodule

// File: rtl/evt_delta.sv
// Interval former. On capture it subtracts the previous timestamp from
// the new one modulo 2^TS_W (zero for the first event of a run) and
// registers the packed record {states, interval}.
module evt_delta
    import evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             first,
    input  logic [REC_W-1:0] word,
    output logic [REC_W-1:0] rec
);
    logic [TS_W-1:0]  prev_q;
    logic [TS_W-1:0]  ts;
    logic [TS_W-1:0]  interval;
    logic [REC_W-1:0] rec_q;

    assign ts       = word[TS_W-1:0];
    assign interval = first ? '0 : (ts - prev_q);
    assign rec      = rec_q;

    // Hold the last timestamp and the packed record of the current event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            rec_q  <= '0;
        end else if (capture) begin
            prev_q <= ts;
            rec_q  <= {word[REC_W-1 -: ST_W], interval};
        end
    end
endmodule

// File: rtl/evt_serializer.sv
// Event interval packer and serializer (top). On an idle start with a
// nonzero count it reads events 0..count-1, forms interval records and
// sends each as three bytes, MSB byte first. Assumes rd_data is valid
// one cycle after rd_addr and that memory is not rewritten while busy.
module evt_serializer
    import evt_pkg::*;
#(
    parameter int CLK_HZ  = 50_000_000,
    parameter int BAUD_HZ = 19_200,
    parameter int ADDR_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W:0]   evt_count,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [REC_W-1:0]  rd_data,
    output logic              busy,
    output logic              tx
);
    localparam int DIV = (CLK_HZ + BAUD_HZ / 2) / BAUD_HZ;

    ser_state_t        state_q;
    logic [ADDR_W:0]   cnt_q;
    logic [ADDR_W-1:0] idx_q;
    logic [1:0]        bsel_q;
    logic [REC_W-1:0]  rec;
    logic              last_evt;
    logic              last_byte;
    logic              capture;
    logic              uart_load;
    logic              uart_active;

    assign last_evt  = ({1'b0, idx_q} + (ADDR_W + 1)'(1)) == cnt_q;
    assign last_byte = bsel_q == 2'(BYTES - 1);
    assign capture   = state_q == S_CALC;
    assign uart_load = state_q == S_LOAD;
    assign busy      = state_q != S_IDLE;
    assign rd_addr   = idx_q;

    evt_delta u_delta (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(capture),
        .first  (idx_q == '0),
        .word   (rd_data),
        .rec    (rec)
    );

    evt_uart_tx #(.DIV(DIV)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (uart_load),
        .data  (rec_byte(rec, bsel_q)),
        .active(uart_active),
        .tx    (tx)
    );

    // Sequencer: read, form record, send three bytes, next event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            bsel_q  <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (start && evt_count != '0) begin
                        cnt_q   <= evt_count;
                        idx_q   <= '0;
                        state_q <= S_READ;
                    end
                end
                S_READ: state_q <= S_CALC;
                S_CALC: begin
                    bsel_q  <= '0;
                    state_q <= S_LOAD;
                end
                S_LOAD: state_q <= S_WAIT;
                S_WAIT: begin
                    if (!uart_active) begin
                        if (!last_byte) begin
                            bsel_q  <= bsel_q + 1'b1;
                            state_q <= S_LOAD;
                        end else if (last_evt) begin
                            state_q <= S_IDLE;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= S_READ;
                        end
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/evt_serializer_checker.sv
// Port-level properties of the event serializer, bound to every instance.
module evt_serializer_checker #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W:0]   evt_count,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              busy,
    input logic              tx
);
    // R6: the line is idle high whenever no transfer runs
    assert_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx);

    // R6: a transfer ends only after a stop bit, so the line is high then
    assert_stop_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> tx);

    // R7: a zero-count start is not accepted
    assert_zero_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && evt_count == '0) |=> !busy);

    // R6: a nonzero-count start while idle begins a transfer
    assert_start_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && evt_count != '0) |=> busy);

    // R9: every run reads from address zero first
    assert_first_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> rd_addr == '0);

    // R9: addresses within a run hold or step up by one
    assert_addr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
            (rd_addr == $past(rd_addr) || rd_addr == $past(rd_addr) + 1'b1));
endmodule

bind evt_serializer evt_serializer_checker #(.ADDR_W(ADDR_W)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .evt_count(evt_count),
    .rd_addr  (rd_addr),
    .busy     (busy),
    .tx       (tx)
);

// File: tb/evt_serializer_bench.sv
module evt_serializer_bench;
    localparam int CLK_HZ  = 76_800;
    localparam int BAUD_HZ = 19_200;
    localparam int DIV     = 4;
    localparam int ADDR_W  = 4;
    localparam int DEPTH   = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W:0]   evt_count = '0;
    logic [ADDR_W-1:0] rd_addr;
    logic [23:0]       rd_data = '0;
    logic              busy;
    logic              tx;

    logic [23:0] mem [0:DEPTH-1];
    logic [7:0]  rxq [$];
    int          ferr = 0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    evt_serializer #(.CLK_HZ(CLK_HZ), .BAUD_HZ(BAUD_HZ), .ADDR_W(ADDR_W)) u_evt_serializer (
        .clk(clk), .rst_n(rst_n), .start(start), .evt_count(evt_count),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .tx(tx)
    );

    always @(posedge clk) rd_data <= mem[rd_addr];

    // Serial receiver sampling mid-bit on falling clock edges (R5 framing).
    initial begin
        forever begin
            @(negedge clk);
            if (tx == 1'b0) begin
                logic [7:0] b;
                repeat (DIV / 2) @(negedge clk);
                if (tx !== 1'b0) ferr++;
                for (int i = 0; i < 8; i++) begin
                    repeat (DIV) @(negedge clk);
                    b[i] = tx;
                end
                repeat (DIV) @(negedge clk);
                if (tx !== 1'b1) ferr++;
                rxq.push_back(b);
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_rec(input int i);
        logic [20:0] iv;
        iv = (i == 0) ? 21'd0 : (mem[i][20:0] - mem[i-1][20:0]);
        return {mem[i][23:21], iv};
    endfunction

    // Run a transfer of n events and compare the received stream.
    task automatic run(input int n, input bit poke);
        rxq.delete();
        ferr = 0;
        @(negedge clk);
        evt_count = (ADDR_W + 1)'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(busy === 1'b1, "R6 busy after start", {31'd0, busy}, 1);
        if (poke) begin
            repeat (30) @(negedge clk);
            evt_count = 1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy === 1'b1 && !done) @(negedge clk);
        check(tx === 1'b1, "R6 idle line after run", {31'd0, tx}, 1);
        check(ferr == 0, "R5 framing", ferr, 0);
        check(rxq.size() == 3 * n, poke ? "R8 byte count" : "R2 byte count",
              rxq.size(), 3 * n);
        for (int i = 0; i < n && rxq.size() == 3 * n; i++) begin
            logic [23:0] e;
            logic [23:0] a;
            e = exp_rec(i);
            a = {rxq[3*i], rxq[3*i+1], rxq[3*i+2]};
            check(a == e, (i == 0) ? "R1/R4 first record" : "R1/R2/R3 record", a, e);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && tx === 1'b1, "R6 reset state", {30'd0, busy, tx}, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7: zero count sends nothing
        rxq.delete();
        evt_count = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (busy) seen = 1'b1;
            end
            check(!seen, "R7 busy stays low", {31'd0, seen}, 0);
            check(rxq.size() == 0, "R7 no bytes", rxq.size(), 0);
        end

        // R3/R4 directed: equal stamps, wrap, maximum interval
        mem[0] = {3'b100, 21'd100};
        mem[1] = {3'b010, 21'd100};
        mem[2] = {3'b001, 21'h1FFFF0};
        mem[3] = {3'b111, 21'h000010};
        mem[4] = {3'b000, 21'h00000F};
        run(5, 1'b0);
        check(exp_rec(3)[20:0] == 21'h20, "R3 wrap expectation", exp_rec(3), 21'h20);

        // R8: start pulse during a run is ignored
        for (int i = 0; i < 4; i++) mem[i] = {$urandom} & 24'hFFFFFF;
        run(4, 1'b1);

        // Random runs
        for (int r = 0; r < 5; r++) begin
            int n;
            n = 1 + ($urandom % 8);
            for (int i = 0; i < n; i++) mem[i] = {$urandom} & 24'hFFFFFF;
            run(n, 1'b0);
        end

        // R4: single event always reports zero interval
        mem[0] = {3'b101, 21'h0ABCDE};
        run(1, 1'b0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150_000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule